// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block gathers the data bytes of one non-volatile programming cycle and later hands them to the storage array as a single page. A start pulse opens a load phase and carries a starting address. The upper bits of that address fix the page for the whole cycle. Its low four bits choose the first slot of a 16-slot buffer. Each byte strobe writes one byte into the current slot and then moves the slot pointer forward. The pointer wraps inside the page, so a long burst overwrites bytes that were loaded earlier.

A commit pulse ends the load phase and starts programming. The block then emits one array write per clock. It writes only the slots that were actually loaded, in ascending slot order, and holds a busy flag while it does so. An abort pulse throws away everything loaded so far. The serial front end that shifts bits and decodes instructions sits outside this block and drives its pulses.

Top module: `eeprom_page_buffer`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low.
- R2: A start pulse when idle takes the page from `start_addr_i[9:4]` and the first slot from `start_addr_i[3:0]`. Successive bytes land in consecutive slots and are written to address {page, slot}.
- R3: After slot 15 the pointer wraps to slot 0 of the same page. A later byte replaces the earlier byte in the same slot. The page bits of `arr_addr_o` do not change during one programming cycle.
- R4: During programming, only loaded slots are written, one per clock, in strictly ascending slot order.
- R5: A cycle with a single loaded byte produces exactly one array write.
- R6: `busy_o` rises only in the cycle after an accepted commit. It stays high for exactly as many cycles as there are writes, and `arr_we_o` is high in each of those cycles.
- R7: Start and byte strobes that arrive while `busy_o` is high have no effect on the data or addresses written.
- R8: An abort during the load phase discards the buffered bytes. A later commit without a new start writes nothing.
- R9: A commit with no byte loaded writes nothing and leaves `busy_o` low.
- R10: A byte strobe in the same cycle as a commit is loaded and is included in the programming cycle.
- R11: An abort in the same cycle as a commit wins: nothing is written and `busy_o` stays low.
- R12: A commit while idle, with no load phase open, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a load phase |
| start_addr_i | input | 10 | Starting address: page in bits 9:4, first slot in bits 3:0 |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Ends loading and starts programming |
| abort_i | input | 1 | Discards the load phase |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 10 | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Programming in progress |

## Verification
Two pairs of events can land on the same clock edge. The first is a byte strobe together with a commit. The second is an abort together with a commit. The bench drives each pair in one cycle. It then checks whether the captured array writes contain the last byte, in the first case, or contain nothing at all, in the second. A third collision is a start or byte strobe during the first write cycle. The bench judges it by comparing the written addresses and data against the model taken before the disturbance.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PWB_IDLE = 2'd0,
    PWB_LOAD = 2'd1,
    PWB_PROG = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/pwb_lowest_pick.sv
module pwb_lowest_pick #(
  parameter int SLOTS  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] mask,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SLOTS  = 16,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic [IDX_W-1:0]  pick_idx_i,
  output pwb_state_e        state_o,
  output logic [SLOTS-1:0]  mask_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              store_en_o,
  output logic [IDX_W-1:0]  store_idx_o
);
  pwb_state_e        state_q, state_d;
  logic [SLOTS-1:0]  mask_q, mask_d, mask_tmp;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    state_d    = state_q;
    mask_d     = mask_q;
    ptr_d      = ptr_q;
    page_d     = page_q;
    store_en_o = 1'b0;
    mask_tmp   = mask_q;
    unique case (state_q)
      PWB_IDLE: begin
        if (start_i) begin
          state_d = PWB_LOAD;
          ptr_d   = start_addr_i[IDX_W-1:0];
          page_d  = start_addr_i[ADDR_W-1:IDX_W];
          mask_d  = '0;
        end
      end
      PWB_LOAD: begin
        if (abort_i) begin
          state_d = PWB_IDLE;
          mask_d  = '0;
        end else if (start_i) begin
          ptr_d  = start_addr_i[IDX_W-1:0];
          page_d = start_addr_i[ADDR_W-1:IDX_W];
          mask_d = '0;
        end else begin
          if (byte_vld_i) begin
            store_en_o       = 1'b1;
            mask_tmp[ptr_q]  = 1'b1;
            ptr_d            = ptr_q + 1'b1;
          end
          mask_d = mask_tmp;
          if (commit_i) begin
            state_d = (|mask_tmp) ? PWB_PROG : PWB_IDLE;
          end
        end
      end
      PWB_PROG: begin
        mask_d = mask_q & ~(SLOTS'(1) << pick_idx_i);
        if (mask_d == '0) begin
          state_d = PWB_IDLE;
        end
      end
      default: begin
        state_d = PWB_IDLE;
        mask_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWB_IDLE;
      mask_q  <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      ptr_q   <= ptr_d;
      page_q  <= page_d;
    end
  end

  assign state_o     = state_q;
  assign mask_o      = mask_q;
  assign page_o      = page_q;
  assign store_idx_o = ptr_q;
endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 16,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o
);
  pwb_state_e        state;
  logic [SLOTS-1:0]  mask;
  logic [PAGE_W-1:0] page;
  logic              store_en;
  logic [IDX_W-1:0]  store_idx;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;

  pwb_ctrl #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .byte_vld_i   (byte_vld_i),
    .commit_i     (commit_i),
    .abort_i      (abort_i),
    .pick_idx_i   (pick_idx),
    .state_o      (state),
    .mask_o       (mask),
    .page_o       (page),
    .store_en_o   (store_en),
    .store_idx_o  (store_idx)
  );

  pwb_slot_store #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_en),
    .wr_idx  (store_idx),
    .wr_data (byte_i),
    .rd_idx  (pick_idx),
    .rd_data (arr_data_o)
  );

  pwb_lowest_pick #(.SLOTS(SLOTS)) u_pick (
    .mask (mask),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  assign busy_o     = (state == PWB_PROG);
  assign arr_we_o   = busy_o && pick_any;
  assign arr_addr_o = {page, pick_idx};
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W = 10,
  parameter int SLOTS  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_i,
  input logic              abort_i,
  input logic              busy_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  AST_ASCENDING_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o[IDX_W-1:0] > $past(arr_addr_o[IDX_W-1:0]))); // R4
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o[ADDR_W-1:IDX_W] == $past(arr_addr_o[ADDR_W-1:IDX_W]))); // R3
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !busy_o) |=> !busy_o); // R11
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> $past(commit_i)); // R6
  AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> arr_we_o); // R6
endmodule

bind eeprom_page_buffer pwb_checker #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_pwb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit_i   (commit_i),
  .abort_i    (abort_i),
  .busy_o     (busy_o),
  .arr_we_o   (arr_we_o),
  .arr_addr_o (arr_addr_o)
);

// File: tb/tb_eeprom_page_buffer.sv
module tb_eeprom_page_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_addr_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       commit_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       arr_we_o;
  logic [9:0] arr_addr_o;
  logic [7:0] arr_data_o;
  logic       busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  m_data [16];
  logic [15:0] m_mask;
  logic [3:0]  m_ptr;
  logic [5:0]  m_page;

  always #2 clk = ~clk;

  eeprom_page_buffer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i), .abort_i(abort_i),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [9:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    m_page = a[9:4]; m_ptr = a[3:0]; m_mask = '0;
  endtask

  task automatic do_byte(input logic [7:0] b, input bit with_commit);
    byte_vld_i = 1'b1; byte_i = b; commit_i = with_commit;
    @(negedge clk);
    byte_vld_i = 1'b0; commit_i = 1'b0;
    m_data[m_ptr] = b; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1;
  endtask

  task automatic do_commit(input bit with_abort);
    commit_i = 1'b1; abort_i = with_abort;
    @(negedge clk);
    commit_i = 1'b0; abort_i = 1'b0;
  endtask

  // Compare the writes that follow a commit against the model; disturb drives start/byte in the first write cycle.
  task automatic expect_writes(input string req, input bit disturb);
    int n_exp = 0;
    int n = 0;
    for (int s = 0; s < 16; s++) if (m_mask[s]) n_exp++;
    check(busy_o == (n_exp != 0), {req, " busy after commit"}, busy_o, n_exp != 0);
    if (disturb) begin
      start_i = 1'b1; start_addr_i = 10'h3F0; byte_vld_i = 1'b1; byte_i = 8'hEE;
    end
    for (int s = 0; s < 16; s++) begin
      if (m_mask[s]) begin
        check(busy_o && arr_we_o, {req, " we/busy in write cycle"}, {busy_o, arr_we_o}, 3);
        check(arr_addr_o == {m_page, 4'(s)}, {req, " addr"}, arr_addr_o, {m_page, 4'(s)});
        check(arr_data_o == m_data[s], {req, " data"}, arr_data_o, m_data[s]);
        n++;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
      end
    end
    check(!busy_o && !arr_we_o, {req, " R6 busy ends after last write"}, busy_o, 0);
    m_mask = '0;
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      check(!busy_o && !arr_we_o, req, {busy_o, arr_we_o}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(!busy_o && !arr_we_o, "R1 reset state", {busy_o, arr_we_o}, 0);
  endtask

  task automatic t_multi();
    do_start(10'h123);
    for (int i = 0; i < 5; i++) do_byte(8'h10 + 8'(i), 1'b0);
    do_commit(1'b0);
    expect_writes("R2 R4 R6 multi", 1'b0);
  endtask

  task automatic t_wrap();
    do_start(10'h2FE);
    for (int i = 0; i < 18; i++) do_byte(8'hA0 + 8'(i), 1'b0);
    do_commit(1'b0);
    expect_writes("R3 wrap", 1'b0);
  endtask

  task automatic t_single();
    do_start(10'h3A5);
    do_byte(8'h5C, 1'b0);
    do_commit(1'b0);
    expect_writes("R5 single", 1'b0);
  endtask

  task automatic t_busy_ignore();
    do_start(10'h048);
    for (int i = 0; i < 3; i++) do_byte(8'h70 + 8'(i), 1'b0);
    do_commit(1'b0);
    expect_writes("R7 busy ignore", 1'b1);
    expect_quiet("R7 no load after busy", 2);
    do_commit(1'b0);
    expect_quiet("R12 idle commit ignored", 3);
  endtask

  task automatic t_abort();
    do_start(10'h150);
    do_byte(8'h11, 1'b0);
    do_byte(8'h22, 1'b0);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    m_mask = '0;
    expect_quiet("R8 abort quiet", 2);
    do_commit(1'b0);
    expect_quiet("R8 commit after abort", 3);
  endtask

  task automatic t_empty();
    do_start(10'h260);
    do_commit(1'b0);
    expect_quiet("R9 empty commit", 3);
  endtask

  task automatic t_byte_commit();
    do_start(10'h09C);
    do_byte(8'h31, 1'b0);
    do_byte(8'h32, 1'b1);
    expect_writes("R10 byte with commit", 1'b0);
  endtask

  task automatic t_abort_commit();
    do_start(10'h1E2);
    do_byte(8'h41, 1'b0);
    do_commit(1'b1);
    m_mask = '0;
    expect_quiet("R11 abort with commit", 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_multi();
    t_wrap();
    t_single();
    t_busy_ignore();
    t_abort();
    t_empty();
    t_byte_commit();
    t_abort_commit();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule